// File: doc/BRIEF.md
# Dual-Channel Bus-Master DMA Register Block

This block holds the host-visible control state of a two-channel bus-master DMA controller for IDE-style storage. The registers sit in a 16-byte I/O window. Each channel owns an 8-byte slice of that window. In each slice, the first 32-bit word carries a command byte and a status byte, and the second word carries the descriptor-table pointer. The host reaches the window through one 32-bit word port. It selects the word with a word index and picks the bytes to write with four byte enables, so 8-, 16- and 32-bit host accesses all map onto the same port.

The DMA engine uses per-channel side inputs to drive the live "active" flag and to pulse the error and interrupt flags. Per channel, the block sends back the start control, the direction control and the descriptor pointer, and it raises an interrupt request while the interrupt flag is set. Reads are combinational on the addressed word. Writes take effect at the next rising clock edge.

Top module: `bmdma_regs`

## Requirements
- R1: After a synchronous active-low reset, every command, status and pointer register is zero, and `dma_start`, `dma_to_mem`, `desc_ptr` and `irq_req` are all zero.
- R2: Word index bit 0 selects the word within a channel: 0 is the command/status word and 1 is the pointer word. The bits above it select the channel. Index 0 and 1 belong to channel 0, and index 2 and 3 belong to channel 1. A write to one channel never changes the other channel.
- R3: In a command/status word, byte lane 0 is the command byte and lane 2 is the status byte. Lanes 1 and 3 always read 0xFF, and writes to them have no effect.
- R4: Command bit 0 is start and drives `dma_start`. Command bit 3 is direction (1 = device to memory) and drives `dma_to_mem`. The other command bits always read zero. The command byte changes only when lane 0 of its word is written.
- R5: Status bit 0 (bit 16 of the word) always reads the channel's `eng_active` input. A status write has no effect on it.
- R6: Status bit 1 (error) and bit 2 (interrupt) are write-one-to-clear. A written 1 clears the bit and a written 0 leaves it unchanged.
- R7: A one-cycle `eng_err_set` or `eng_irq_set` pulse sets status bit 1 or bit 2. When a set pulse and a clearing write land in the same cycle, the bit ends up set.
- R8: Status bits 5 and 6 are read/write and take the written data. Status bits 3, 4 and 7 always read zero.
- R9: The pointer word can be written through any combination of byte enables. Each enabled lane loads its byte and the other lanes keep their value. Bits 1:0 of the pointer always read zero.
- R10: `irq_req` for a channel is high exactly while that channel's status bit 2 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_word | input | 2 | Word index in the window (channel, word) |
| io_be | input | 4 | Byte enables for writes |
| io_we | input | 1 | Write strobe |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data of the addressed word |
| eng_active | input | 2 | Per-channel engine busy flag |
| eng_err_set | input | 2 | Per-channel error set pulse |
| eng_irq_set | input | 2 | Per-channel interrupt set pulse |
| dma_start | output | 2 | Per-channel start control |
| dma_to_mem | output | 2 | Per-channel direction control |
| desc_ptr | output | 64 | Descriptor pointers, channel 1 in bits 63:32 |
| irq_req | output | 2 | Per-channel interrupt request |

## Verification
The hardest case to reach from the ports is the collision of an engine set pulse with a host write-one-to-clear of the same status bit in a single cycle. The outcome depends only on which of the two wins. The bench drives the set pulse and the write strobe from the same negative clock edge, so both are sampled at one rising edge. It then reads the status byte and `irq_req` to confirm that the bit stayed set. It also checks that, after the pulse is gone, a later clearing write does remove the bit.

// File: rtl/bmdma_pkg.sv
// Package: shared constants for the bus-master DMA register block.
// Assumes: the window is split into equal 8-byte channel slices of two 32-bit words.
package bmdma_pkg;
    localparam int DATA_W    = 32;
    localparam int LANES     = DATA_W / 8;
    // status bit positions inside the status byte
    localparam int ST_ACTIVE = 0;
    localparam int ST_ERR    = 1;
    localparam int ST_IRQ    = 2;
    localparam int ST_CAP0   = 5;
    localparam int ST_CAP1   = 6;
    // command bit positions inside the command byte
    localparam int CMD_START = 0;
    localparam int CMD_DIR   = 3;
    // byte lanes inside the command/status word
    localparam int LANE_CMD  = 0;
    localparam int LANE_STAT = 2;
    localparam logic [7:0] PAD_BYTE = 8'hFF;
endpackage

// File: rtl/bmdma_decode.sv
// Module: address decode for the register window.
// Splits the word index into a channel and a word select, and turns
// a host write into one-hot per-channel command/status or pointer write strobes.
// Assumes: NUM_CH is a power of two.
module bmdma_decode #(
    parameter int NUM_CH = 2,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [CH_W:0]      io_word,
    input  logic               io_we,
    output logic [NUM_CH-1:0]  ctl_we,
    output logic [NUM_CH-1:0]  ptr_we
);
    logic [CH_W-1:0] ch_sel;
    logic            is_ptr;

    assign ch_sel = io_word[CH_W:1];
    assign is_ptr = io_word[0];

    // one strobe per channel and word kind
    always_comb begin
        ctl_we = '0;
        ptr_we = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (io_we && (ch_sel == CH_W'(c))) begin
                ctl_we[c] = !is_ptr;
                ptr_we[c] = is_ptr;
            end
        end
    end
endmodule

// File: rtl/bmdma_chan.sv
// Module: register set for one DMA channel.
// Holds the command byte, the stored status bits and the descriptor pointer.
// Assumes: write strobes are already decoded for this channel; set pulses
// from the engine are one cycle wide and win over a same-cycle host clear.
module bmdma_chan
    import bmdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic              ptr_we,
    input  logic [LANES-1:0]  be,
    input  logic [DATA_W-1:0] wdata,
    input  logic              active,
    input  logic              err_set,
    input  logic              irq_set,
    output logic [DATA_W-1:0] ctl_word,
    output logic [DATA_W-1:0] ptr_q,
    output logic              start,
    output logic              to_mem,
    output logic              irq_req
);
    logic              cmd_start, cmd_dir;
    logic              st_err, st_irq;
    logic [1:0]        st_cap;
    logic [DATA_W-1:2] ptr_r;
    logic [DATA_W-1:0] ptr_merge;
    logic [7:0]        cmd_byte, stat_byte, stat_wr;
    logic              cmd_wr, stat_we;

    assign cmd_byte = wdata[LANE_CMD*8 +: 8];
    assign stat_wr  = wdata[LANE_STAT*8 +: 8];
    assign cmd_wr   = ctl_we && be[LANE_CMD];
    assign stat_we  = ctl_we && be[LANE_STAT];

    // command register: only start and direction are stored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_start <= 1'b0;
            cmd_dir   <= 1'b0;
        end else if (cmd_wr) begin
            cmd_start <= cmd_byte[CMD_START];
            cmd_dir   <= cmd_byte[CMD_DIR];
        end
    end

    // event bits: set pulse wins, otherwise a written one clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_err <= 1'b0;
            st_irq <= 1'b0;
        end else begin
            st_err <= err_set | (st_err & ~(stat_we & stat_wr[ST_ERR]));
            st_irq <= irq_set | (st_irq & ~(stat_we & stat_wr[ST_IRQ]));
        end
    end

    // capability bits: plain read/write
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_cap <= 2'b00;
        else if (stat_we)
            st_cap <= {stat_wr[ST_CAP1], stat_wr[ST_CAP0]};
    end

    // pointer byte merge under the byte enables
    always_comb begin
        ptr_merge = {ptr_r, 2'b00};
        for (int l = 0; l < LANES; l++) begin
            if (be[l])
                ptr_merge[l*8 +: 8] = wdata[l*8 +: 8];
        end
    end

    // pointer register: low two bits are never stored
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_r <= '0;
        else if (ptr_we)
            ptr_r <= ptr_merge[DATA_W-1:2];
    end

    // assemble the command and status bytes as seen by the host
    always_comb begin
        stat_byte            = '0;
        stat_byte[ST_ACTIVE] = active;
        stat_byte[ST_ERR]    = st_err;
        stat_byte[ST_IRQ]    = st_irq;
        stat_byte[ST_CAP0]   = st_cap[0];
        stat_byte[ST_CAP1]   = st_cap[1];
    end

    // word view: pad lanes read all ones
    always_comb begin
        ctl_word                   = {LANES{PAD_BYTE}};
        ctl_word[LANE_CMD*8 +: 8]  = '0;
        ctl_word[LANE_CMD*8 + CMD_START] = cmd_start;
        ctl_word[LANE_CMD*8 + CMD_DIR]   = cmd_dir;
        ctl_word[LANE_STAT*8 +: 8] = stat_byte;
    end

    assign ptr_q   = {ptr_r, 2'b00};
    assign start   = cmd_start;
    assign to_mem  = cmd_dir;
    assign irq_req = st_irq;
endmodule

// File: rtl/bmdma_rdmux.sv
// Module: read multiplexer for the register window.
// Picks the addressed channel's command/status word or pointer word.
// Assumes: NUM_CH is a power of two; reads are purely combinational.
module bmdma_rdmux
    import bmdma_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [CH_W:0]                  io_word,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  ctl_words,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  ptr_words,
    output logic [DATA_W-1:0]              rdata
);
    logic [CH_W-1:0] ch_sel;

    assign ch_sel = io_word[CH_W:1];

    // select channel, then word kind
    always_comb begin
        rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_sel == CH_W'(c))
                rdata = io_word[0] ? ptr_words[c] : ctl_words[c];
        end
    end
endmodule

// File: rtl/bmdma_regs.sv
// Module: top of the dual-channel bus-master DMA register block.
// Decodes host word accesses, holds one register set per channel and
// returns the addressed word. Assumes NUM_CH is a power of two.
module bmdma_regs
    import bmdma_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CH_W:0]            io_word,
    input  logic [LANES-1:0]         io_be,
    input  logic                     io_we,
    input  logic [DATA_W-1:0]        io_wdata,
    output logic [DATA_W-1:0]        io_rdata,
    input  logic [NUM_CH-1:0]        eng_active,
    input  logic [NUM_CH-1:0]        eng_err_set,
    input  logic [NUM_CH-1:0]        eng_irq_set,
    output logic [NUM_CH-1:0]        dma_start,
    output logic [NUM_CH-1:0]        dma_to_mem,
    output logic [NUM_CH*DATA_W-1:0] desc_ptr,
    output logic [NUM_CH-1:0]        irq_req
);
    logic [NUM_CH-1:0]             ctl_we, ptr_we;
    logic [NUM_CH-1:0][DATA_W-1:0] ctl_words, ptr_words;

    bmdma_decode #(.NUM_CH(NUM_CH)) u_dec (
        .io_word (io_word),
        .io_we   (io_we),
        .ctl_we  (ctl_we),
        .ptr_we  (ptr_we)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        bmdma_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctl_we   (ctl_we[c]),
            .ptr_we   (ptr_we[c]),
            .be       (io_be),
            .wdata    (io_wdata),
            .active   (eng_active[c]),
            .err_set  (eng_err_set[c]),
            .irq_set  (eng_irq_set[c]),
            .ctl_word (ctl_words[c]),
            .ptr_q    (ptr_words[c]),
            .start    (dma_start[c]),
            .to_mem   (dma_to_mem[c]),
            .irq_req  (irq_req[c])
        );
        assign desc_ptr[c*DATA_W +: DATA_W] = ptr_words[c];
    end

    bmdma_rdmux #(.NUM_CH(NUM_CH)) u_rd (
        .io_word   (io_word),
        .ctl_words (ctl_words),
        .ptr_words (ptr_words),
        .rdata     (io_rdata)
    );
endmodule

// File: rtl/bmdma_regs_chk.sv
// Module: property checker for bmdma_regs, attached by bind.
// Assumes: observes only the top module's ports.
module bmdma_regs_chk
    import bmdma_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [CH_W:0]            io_word,
    input logic [LANES-1:0]         io_be,
    input logic                     io_we,
    input logic [DATA_W-1:0]        io_wdata,
    input logic [DATA_W-1:0]        io_rdata,
    input logic [NUM_CH-1:0]        eng_active,
    input logic [NUM_CH-1:0]        eng_err_set,
    input logic [NUM_CH-1:0]        eng_irq_set,
    input logic [NUM_CH-1:0]        dma_start,
    input logic [NUM_CH-1:0]        dma_to_mem,
    input logic [NUM_CH*DATA_W-1:0] desc_ptr,
    input logic [NUM_CH-1:0]        irq_req
);
    AST_PAD_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        !io_word[0] |-> (io_rdata[15:8] == 8'hFF && io_rdata[31:24] == 8'hFF)); // R3
    AST_ACTIVE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !io_word[0] |-> io_rdata[16] == eng_active[io_word[CH_W:1]]); // R5
    AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        io_word[0] |-> io_rdata[1:0] == 2'b00); // R9
    AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        eng_irq_set[0] |=> irq_req[0]); // R7
    AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (io_we && io_word == '0 && io_be[2] && io_wdata[18] && !eng_irq_set[0]) |=> !irq_req[0]); // R6
    AST_IRQ_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        io_word == '0 |-> io_rdata[18] == irq_req[0]); // R10
    AST_START_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_we && io_word == '0 && io_be[0]) |=> $stable(dma_start[0])); // R4
endmodule

bind bmdma_regs bmdma_regs_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/tb_bmdma_regs.sv
module tb_bmdma_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  io_word = '0;
    logic [3:0]  io_be = '0;
    logic        io_we = 1'b0;
    logic [31:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic [1:0]  eng_active = '0, eng_err_set = '0, eng_irq_set = '0;
    logic [1:0]  dma_start, dma_to_mem, irq_req;
    logic [63:0] desc_ptr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bmdma_regs dut (.*);

    // row: {write, word, be, data, expected read}
    localparam int NV = 15;
    localparam logic [70:0] VEC [NV] = '{
        {1'b1, 2'd0, 4'b0001, 32'h000000FF, 32'h0},          // R4 command write
        {1'b0, 2'd0, 4'b0000, 32'h0, 32'hFF00FF09},          // R4 R3
        {1'b1, 2'd0, 4'b1010, 32'h12341234, 32'h0},          // R3 pad lanes write
        {1'b0, 2'd0, 4'b0000, 32'h0, 32'hFF00FF09},          // R3
        {1'b1, 2'd0, 4'b0100, 32'h00FF0000, 32'h0},          // R8 status write
        {1'b0, 2'd0, 4'b0000, 32'h0, 32'hFF60FF09},          // R8
        {1'b1, 2'd1, 4'b1111, 32'h12345677, 32'h0},          // R9
        {1'b0, 2'd1, 4'b0000, 32'h0, 32'h12345674},          // R9
        {1'b1, 2'd1, 4'b0010, 32'h0000AB00, 32'h0},          // R9 byte
        {1'b1, 2'd1, 4'b1100, 32'hCAFE0000, 32'h0},          // R9 half
        {1'b0, 2'd1, 4'b0000, 32'h0, 32'hCAFEAB74},          // R9
        {1'b1, 2'd2, 4'b0001, 32'h00000008, 32'h0},          // R2 channel 1
        {1'b0, 2'd2, 4'b0000, 32'h0, 32'hFF00FF08},          // R2
        {1'b0, 2'd0, 4'b0000, 32'h0, 32'hFF60FF09},          // R2 channel 0 kept
        {1'b0, 2'd3, 4'b0000, 32'h0, 32'h00000000}           // R2
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] w, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        io_word = w; io_be = be; io_wdata = d; io_we = 1'b1;
        @(negedge clk);
        io_we = 1'b0; io_be = '0;
    endtask

    task automatic rd(input logic [1:0] w, input logic [31:0] exp, input string req);
        @(negedge clk);
        io_word = w;
        #1;
        check(req, {32'h0, io_rdata}, {32'h0, exp});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(2'd0, 32'hFF00FF00, "R1");
        rd(2'd3, 32'h0, "R1");
        check("R1", {dma_start, dma_to_mem, irq_req}, '0);
        check("R1", desc_ptr, '0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][70])
                wr(VEC[i][69:68], VEC[i][67:64], VEC[i][63:32]);
            else
                rd(VEC[i][69:68], VEC[i][31:0], $sformatf("R2/R3/R4/R8/R9 row %0d", i));
        end
        check("R4", {dma_start, dma_to_mem}, {2'b01, 2'b11});
        check("R9", desc_ptr, 64'h00000000_CAFEAB74);

        // R4 other bits read zero, start clears
        wr(2'd0, 4'b0001, 32'h000000F6);
        rd(2'd0, 32'hFF60FF00, "R4");
        check("R4", {dma_start[0], dma_to_mem[0]}, 2'b00);

        // R7 error pulse on channel 1, R6 written zero keeps
        @(negedge clk); eng_err_set = 2'b10;
        @(negedge clk); eng_err_set = 2'b00;
        rd(2'd2, 32'hFF02FF08, "R7");
        wr(2'd2, 4'b0100, 32'h00000000);
        rd(2'd2, 32'hFF02FF08, "R6");
        wr(2'd2, 4'b0100, 32'h00020000);
        rd(2'd2, 32'hFF00FF08, "R6");

        // R10 interrupt pulse on channel 0
        @(negedge clk); eng_irq_set = 2'b01;
        @(negedge clk); eng_irq_set = 2'b00;
        #1;
        check("R10", {62'h0, irq_req}, 64'h1);
        // R7 set wins over same-cycle clear
        @(negedge clk);
        eng_irq_set = 2'b01;
        io_word = 2'd0; io_be = 4'b0100; io_wdata = 32'h00640000; io_we = 1'b1;
        @(negedge clk);
        eng_irq_set = 2'b00; io_we = 1'b0; io_be = '0;
        rd(2'd0, 32'hFF64FF00, "R7");
        check("R10", {62'h0, irq_req}, 64'h1);
        wr(2'd0, 4'b0100, 32'h00040000);
        #1;
        check("R6", {62'h0, irq_req}, 64'h0);

        // R5 live active bit, immune to writes; R8 bits 3,4,7 zero
        @(negedge clk); eng_active = 2'b01;
        rd(2'd0, 32'hFF01FF00, "R5");
        wr(2'd0, 4'b0100, 32'h00FE0000);
        rd(2'd0, 32'hFF61FF00, "R5");
        @(negedge clk); eng_active = 2'b00;
        rd(2'd0, 32'hFF60FF00, "R5");

        // R1 reset in the middle of operation
        wr(2'd0, 4'b0001, 32'h00000009);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(2'd0, 32'hFF00FF00, "R1");
        rd(2'd1, 32'h0, "R1");
        check("R1", {dma_start, dma_to_mem, irq_req}, '0);
        check("R1", desc_ptr, '0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule